// File: doc/BRIEF.md
# Rotate-and-Mask Bit Field Unit

This block is a purely combinational 32-bit bit-field datapath. A small operation decoder turns a field length `n` and a bit position `b` into three internal quantities: a rotate amount, a mask begin index and a mask end index. The source word is rotated left by the rotate amount and then ANDed with a contiguous mask of ones running from the begin index to the end index. Bit 0 is the most significant bit of every word. When the begin index is greater than the end index, the mask wraps around the end of the word.

Twelve operations are built on this single path:
- extract, left- or right-justified;
- insert, from a left- or right-justified source field;
- rotate left or right by an immediate amount, and rotate left by a register-supplied amount;
- logical shift left or right;
- clear of the leftmost or rightmost bits;
- clear-left-then-shift-left.

Insert operations keep the target word's bits wherever the mask is zero. All other operations leave those bits at zero.

The decoder checks every operand against the limits of its operation and raises an illegal flag when a limit is broken. A record flag enables a three-bit sign/zero condition that is computed from the result. The block is meant to sit in an execution stage that supplies already-decoded operands.

Top module: `rm_unit`

## Requirements
- R1: Extract (op 0 left-justify, op 1 right-justify) takes the `n`-bit field that starts at big-endian bit `b` of `src`. Op 0 places the field at bits 0..n-1 of the result. Op 1 places it at bits 32-n..31. All other result bits are 0.
- R2: Insert (op 2 from a left-justified source field, op 3 from a right-justified one) takes `n` bits of `src` and writes them into bits b..b+n-1 of `tgt`. Op 2 reads source bits 0..n-1. Op 3 reads source bits 32-n..31. Every other result bit equals the same bit of `tgt`.
- R3: Op 4 rotates `src` left by `n`. Op 5 rotates `src` right by `n`. With `n`=0 the result equals `src`.
- R4: Op 6 rotates `src` left by `rot_amt`. It never flags an illegal operand, and `n` and `b` do not affect it.
- R5: Op 7 shifts `src` left by `n` and op 8 shifts it right by `n`. Vacated bits are 0.
- R6: Op 9 clears the leftmost `n` bits of `src`. Op 10 clears the rightmost `n` bits.
- R7: Op 11 clears the leftmost `b` bits of `src` and then shifts the word left by `n`.
- R8: `bad_opnd` is 1 in each of these cases:
  - ops 3..5 and 7..10 (except op 6) when `n` >= 32;
  - ops 0..3 when `n`=0, `n` >= 32 or `b+n` > 32;
  - op 11 when `n` >= 32, `b` >= 32 or `b` < `n`;
  - any op code from 12 to 15.
  
  Whenever `bad_opnd` is 1, `result` is 0.
- R9: `cond` is {negative, positive, zero}. Bit 2 is set when result bit 0 (the MSB) is 1. Bit 1 is set when the result is nonzero and its MSB is 0. Bit 0 is set when the result is zero. `cond` is 000 whenever `rec_en` is 0.
- R10: `tgt` has no effect on the result of any operation other than op 2 and op 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (0..11 defined) |
| src | input | 32 | Source word |
| tgt | input | 32 | Old target word, merged by insert ops |
| fld_len | input | 6 | Field length / shift count `n` |
| fld_pos | input | 6 | Bit position `b` |
| rot_amt | input | 5 | Register-supplied rotate amount |
| rec_en | input | 1 | Enables the condition output |
| result | output | 32 | Rotated and masked result |
| bad_opnd | output | 1 | Operand limit violated |
| cond | output | 3 | {negative, positive, zero} condition |

## Verification
The block holds no state, so a wrong derived rotate amount or mask bound shows at `result` in the same cycle the operands are applied. It usually appears only at particular values of `n` and `b`, such as the wrap of `32-n` at `n`=0 or an end index at bit 31. For that reason the bench sweeps every `n` and `b` from 0 to 33 for all sixteen op codes and over several source patterns, including zero. Expected results are computed from plain shifts and field arithmetic rather than from rotate and mask bounds. A limit-check slip shows on `bad_opnd` and as a result that is forced to zero.

// File: rtl/rm_pkg.sv
// Package: shared operation codes for the rotate-and-mask unit.
// Assumes a 4-bit operation select; codes 12..15 are reserved and illegal.
package rm_pkg;

    typedef enum logic [3:0] {
        OP_EXT_L   = 4'd0,
        OP_EXT_R   = 4'd1,
        OP_INS_L   = 4'd2,
        OP_INS_R   = 4'd3,
        OP_ROT_L   = 4'd4,
        OP_ROT_R   = 4'd5,
        OP_ROT_REG = 4'd6,
        OP_SHL     = 4'd7,
        OP_SHR     = 4'd8,
        OP_CLR_L   = 4'd9,
        OP_CLR_R   = 4'd10,
        OP_CLR_SHL = 4'd11
    } rm_op_e;

endpackage

// File: rtl/rm_decode.sv
// Module: rm_decode
// Converts an operation code plus field length n and position b into a
// rotate amount, mask begin/end indices (bit 0 = MSB), an insert-merge
// select and an operand-illegal flag. All index arithmetic is modulo WIDTH,
// so "WIDTH - 0" naturally becomes 0. Assumes WIDTH is a power of two.
module rm_decode #(
    parameter int WIDTH = 32,
    parameter int LW    = $clog2(WIDTH)
) (
    input  logic [3:0]    op_sel,
    input  logic [LW:0]   fld_len,
    input  logic [LW:0]   fld_pos,
    input  logic [LW-1:0] rot_amt,
    output logic [LW-1:0] sh,
    output logic [LW-1:0] mb,
    output logic [LW-1:0] me,
    output logic          merge,
    output logic          bad
);
    import rm_pkg::*;

    localparam logic [LW-1:0] TOP_IDX = LW'(WIDTH - 1);
    localparam logic [LW+1:0] FULL    = (LW+2)'(WIDTH);

    logic [LW+1:0] n_x, b_x, sum_x;
    logic [LW-1:0] n5, b5, s5;
    logic          n_big, b_big, fld_ok;

    // Widened operands, their sum and the basic range checks.
    always_comb begin
        n_x    = {1'b0, fld_len};
        b_x    = {1'b0, fld_pos};
        sum_x  = n_x + b_x;
        n5     = fld_len[LW-1:0];
        b5     = fld_pos[LW-1:0];
        s5     = sum_x[LW-1:0];
        n_big  = fld_len[LW];
        b_big  = fld_pos[LW];
        fld_ok = (fld_len != '0) && !n_big && (sum_x <= FULL);
    end

    // Per-operation rotate amount, mask bounds and legality.
    always_comb begin
        sh    = '0;
        mb    = '0;
        me    = TOP_IDX;
        merge = 1'b0;
        bad   = 1'b0;
        case (op_sel)
            OP_EXT_L: begin
                sh  = b5;
                me  = n5 - 1'b1;
                bad = !fld_ok;
            end
            OP_EXT_R: begin
                sh  = s5;
                mb  = '0 - n5;
                bad = !fld_ok;
            end
            OP_INS_L: begin
                sh    = '0 - b5;
                mb    = b5;
                me    = s5 - 1'b1;
                merge = 1'b1;
                bad   = !fld_ok;
            end
            OP_INS_R: begin
                sh    = '0 - s5;
                mb    = b5;
                me    = s5 - 1'b1;
                merge = 1'b1;
                bad   = !fld_ok;
            end
            OP_ROT_L: begin
                sh  = n5;
                bad = n_big;
            end
            OP_ROT_R: begin
                sh  = '0 - n5;
                bad = n_big;
            end
            OP_ROT_REG: begin
                sh  = rot_amt;
            end
            OP_SHL: begin
                sh  = n5;
                me  = TOP_IDX - n5;
                bad = n_big;
            end
            OP_SHR: begin
                sh  = '0 - n5;
                mb  = n5;
                bad = n_big;
            end
            OP_CLR_L: begin
                mb  = n5;
                bad = n_big;
            end
            OP_CLR_R: begin
                me  = TOP_IDX - n5;
                bad = n_big;
            end
            OP_CLR_SHL: begin
                sh  = n5;
                mb  = b5 - n5;
                me  = TOP_IDX - n5;
                bad = n_big || b_big || (b_x < n_x);
            end
            default: begin
                bad = 1'b1;
            end
        endcase
    end

    // Legal extract/insert masks never wrap around the word end (R1, R2).
    always_comb begin
        if (!bad && (op_sel <= 4'd3))
            a_r1_no_wrap: assert (mb <= me);
    end

endmodule

// File: rtl/rm_rotator.sv
// Module: rm_rotator
// Logarithmic rotate-left of a WIDTH-bit word, bit 0 being the MSB, so a
// left rotation moves bits toward the vector's high end. One stage per bit
// of the rotate amount; purely combinational.
module rm_rotator #(
    parameter int WIDTH = 32,
    parameter int LW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [LW-1:0]    amt,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [0:LW];

    assign stg[0] = din;

    for (genvar k = 0; k < LW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        // Stage k rotates left by 2^k when amount bit k is set.
        always_comb begin
            if (amt[k])
                stg[k+1] = {stg[k][WIDTH-1-STEP:0], stg[k][WIDTH-1 -: STEP]};
            else
                stg[k+1] = stg[k];
        end
    end

    assign dout = stg[LW];

endmodule

// File: rtl/rm_mask_gen.sv
// Module: rm_mask_gen
// Builds a mask of ones from big-endian index mb through me inclusive.
// When mb > me the run wraps: indices mb..WIDTH-1 and 0..me are set.
module rm_mask_gen #(
    parameter int WIDTH = 32,
    parameter int LW    = $clog2(WIDTH)
) (
    input  logic [LW-1:0]    mb,
    input  logic [LW-1:0]    me,
    output logic [WIDTH-1:0] mask
);
    logic wrap;

    assign wrap = (mb > me);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam logic [LW-1:0] IDX = LW'(i);
        // Big-endian index i maps to vector bit WIDTH-1-i.
        always_comb begin
            if (wrap)
                mask[WIDTH-1-i] = (IDX >= mb) || (IDX <= me);
            else
                mask[WIDTH-1-i] = (IDX >= mb) && (IDX <= me);
        end
    end

endmodule

// File: rtl/rm_cond.sv
// Module: rm_cond
// Sign/zero condition of a result word, gated by the record enable.
// Output order is {negative, positive, zero}; all zero when disabled.
module rm_cond #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    input  logic             rec_en,
    output logic [2:0]       cond
);
    // Classify the value when recording is enabled.
    always_comb begin
        cond = 3'b000;
        if (rec_en) begin
            if (value == '0)
                cond = 3'b001;
            else if (value[WIDTH-1])
                cond = 3'b100;
            else
                cond = 3'b010;
        end
    end

    // R9: at most one condition bit, none when recording is off.
    always_comb begin
        a_r9_cond_onehot: assert ($onehot0(cond));
        if (!rec_en)
            a_r9_cond_off: assert (cond == 3'b000);
    end

endmodule

// File: rtl/rm_unit.sv
// Module: rm_unit (top)
// Combinational rotate-then-mask bit-field unit. The decoder derives a
// rotate amount and mask bounds; insert ops keep the target outside the
// mask, all other ops zero it. An illegal operand forces a zero result.
// Assumes operands are stable within a cycle; no internal state.
module rm_unit #(
    parameter int WIDTH = 32,
    parameter int LW    = $clog2(WIDTH)
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] tgt,
    input  logic [LW:0]      fld_len,
    input  logic [LW:0]      fld_pos,
    input  logic [LW-1:0]    rot_amt,
    input  logic             rec_en,
    output logic [WIDTH-1:0] result,
    output logic             bad_opnd,
    output logic [2:0]       cond
);
    import rm_pkg::*;

    logic [LW-1:0]    sh, mb, me;
    logic             merge;
    logic [WIDTH-1:0] rotated, mask, merged;

    rm_decode #(.WIDTH(WIDTH), .LW(LW)) u_decode (
        .op_sel  (op_sel),
        .fld_len (fld_len),
        .fld_pos (fld_pos),
        .rot_amt (rot_amt),
        .sh      (sh),
        .mb      (mb),
        .me      (me),
        .merge   (merge),
        .bad     (bad_opnd)
    );

    rm_rotator #(.WIDTH(WIDTH), .LW(LW)) u_rot (
        .din  (src),
        .amt  (sh),
        .dout (rotated)
    );

    rm_mask_gen #(.WIDTH(WIDTH), .LW(LW)) u_mask (
        .mb   (mb),
        .me   (me),
        .mask (mask)
    );

    // Merge the masked rotation with the old target (insert) or zeros.
    always_comb begin
        merged = rotated & mask;
        if (merge)
            merged = merged | (tgt & ~mask);
        result = bad_opnd ? '0 : merged;
    end

    rm_cond #(.WIDTH(WIDTH)) u_cond (
        .value  (result),
        .rec_en (rec_en),
        .cond   (cond)
    );

    // Port-level checks on the assembled result.
    always_comb begin
        if (bad_opnd)
            a_r8_bad_zero: assert (result == '0);
        if (!bad_opnd && (op_sel == OP_ROT_L || op_sel == OP_ROT_R || op_sel == OP_ROT_REG))
            a_r3_rot_keeps_ones: assert ($countones(result) == $countones(src));
        if (!bad_opnd && op_sel == OP_SHL)
            a_r5_shl_zero_fill: assert ((result & ~({WIDTH{1'b1}} << fld_len[LW-1:0])) == '0);
    end

endmodule

// File: tb/rm_unit_bench.sv
// Bench for rm_unit: sweeps every op code, n and b in 0..33 over several
// source patterns; expected values come from plain field arithmetic.
module rm_unit_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [3:0]  op_sel;
    logic [31:0] src, tgt;
    logic [5:0]  fld_len, fld_pos;
    logic [4:0]  rot_amt;
    logic        rec_en;
    logic [31:0] result;
    logic        bad_opnd;
    logic [2:0]  cond;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    rm_unit u_rm_unit (
        .op_sel   (op_sel),
        .src      (src),
        .tgt      (tgt),
        .fld_len  (fld_len),
        .fld_pos  (fld_pos),
        .rot_amt  (rot_amt),
        .rec_en   (rec_en),
        .result   (result),
        .bad_opnd (bad_opnd),
        .cond     (cond)
    );

    function automatic logic [63:0] low(input int k);
        return (64'd1 << k) - 64'd1;
    endfunction

    function automatic string tag(input int op);
        case (op)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4, 5:    return "R3";
            6:       return "R4";
            7, 8:    return "R5";
            9, 10:   return "R6";
            11:      return "R7";
            default: return "R8";
        endcase
    endfunction

    // R8 legality, straight from the requirement text.
    function automatic bit legal(input int op, input int n, input int b);
        case (op)
            0, 1, 2, 3:            return (n > 0) && (n < 32) && (b + n <= 32);
            4, 5, 7, 8, 9, 10:     return n < 32;
            6:                     return 1'b1;
            11:                    return (n < 32) && (b < 32) && (b >= n);
            default:               return 1'b0;
        endcase
    endfunction

    // Expected result (R1..R7), zero when illegal (R8).
    function automatic logic [31:0] expect_res(input int op, input int n, input int b,
                                               input int ra, input logic [31:0] s,
                                               input logic [31:0] t);
        logic [63:0] s64, t64, fld, r;
        int sft;
        s64 = {32'd0, s};
        t64 = {32'd0, t};
        r   = 64'd0;
        if (!legal(op, n, b)) return 32'd0;
        case (op)
            0: r = ((s64 >> (32 - b - n)) & low(n)) << (32 - n);
            1: r = (s64 >> (32 - b - n)) & low(n);
            2, 3: begin
                fld = (op == 2) ? ((s64 >> (32 - n)) & low(n)) : (s64 & low(n));
                sft = 32 - b - n;
                r = (t64 & ~(low(n) << sft)) | (fld << sft);
            end
            4: r = (s64 << n) | (s64 >> (32 - n));
            5: r = (s64 >> n) | (s64 << (32 - n));
            6: r = (s64 << ra) | (s64 >> (32 - ra));
            7: r = s64 << n;
            8: r = s64 >> n;
            9: r = s64 & low(32 - n);
            10: r = s64 & ~low(n);
            11: r = (s64 & low(32 - b)) << n;
            default: r = 64'd0;
        endcase
        return r[31:0];
    endfunction

    function automatic logic [2:0] expect_cond(input logic [31:0] r, input logic re);
        if (!re) return 3'b000;
        if (r == 32'd0) return 3'b001;
        return r[31] ? 3'b100 : 3'b010;
    endfunction

    task automatic apply(input int op, input int n, input int b, input int ra,
                         input logic [31:0] s, input logic [31:0] t, input logic re);
        logic [31:0] er;
        logic [2:0]  ec;
        logic        eb;
        @(posedge clk);
        #1;
        op_sel  = 4'(op);
        fld_len = 6'(n);
        fld_pos = 6'(b);
        rot_amt = 5'(ra);
        src     = s;
        tgt     = t;
        rec_en  = re;
        @(negedge clk);
        er = expect_res(op, n, b, ra, s, t);
        ec = expect_cond(er, re);
        eb = !legal(op, n, b);
        total++;
        if (result !== er) begin
            bad++;
            $display("FAIL %s%s op=%0d n=%0d b=%0d result actual=%h expected=%h",
                     tag(op), (op == 2 || op == 3) ? "" : "/R10", op, n, b, result, er);
        end
        total++;
        if (bad_opnd !== eb) begin
            bad++;
            $display("FAIL R8 op=%0d n=%0d b=%0d bad_opnd actual=%b expected=%b",
                     op, n, b, bad_opnd, eb);
        end
        total++;
        if (cond !== ec) begin
            bad++;
            $display("FAIL R9 op=%0d n=%0d b=%0d cond actual=%b expected=%b",
                     op, n, b, cond, ec);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hDEAD_BEEF;
        pats[1] = 32'h8000_0001;
        pats[2] = 32'h0F0F_3C5A;
        pats[3] = 32'h0000_0000;
        op_sel = '0; src = '0; tgt = '0; fld_len = '0; fld_pos = '0;
        rot_amt = '0; rec_en = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state check: all-zero operands (op 0 with n=0 is illegal, R8).
        apply(0, 0, 0, 0, 32'd0, 32'd0, 1'b0);
        // R3: rotates by zero return the source unchanged.
        apply(4, 0, 0, 0, 32'h1234_5678, 32'hFFFF_FFFF, 1'b1);
        apply(5, 0, 0, 0, 32'h8765_4321, 32'hFFFF_FFFF, 1'b1);
        // R4: register rotate ignores n/b, even out of range ones.
        for (int ra = 0; ra < 32; ra++)
            apply(6, 40 % 64, 63, ra, 32'hC000_0005, 32'h5555_AAAA, 1'b1);
        // Full sweep: R1..R10 over all op codes, n and b in 0..33.
        for (int p = 0; p < 4; p++)
            for (int op = 0; op < 16; op++)
                for (int n = 0; n < 34; n++)
                    for (int b = 0; b < 34; b++)
                        apply(op, n, b, (n + 3 * b) % 32, pats[p],
                              ~pats[p] ^ 32'h1234_5678 ^ 32'(b << 3),
                              1'((n ^ b ^ p) & 1));
        // R10: same non-insert operation under two different targets.
        apply(9, 7, 2, 0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
        apply(9, 7, 2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule